// File: doc/BRIEF.md
# ALU with Condition Flags and Condition Evaluation

This block carries out one of four 32-bit arithmetic or logic operations on two operands, picked by a 4-bit operation code, and returns the result in the same cycle. Next to the datapath sits a three-bit flag register that holds zero, negative and signed-overflow flags. The register captures the flags of the current operation on a rising clock edge, but only when the flag-write strobe is high and the operation code is valid.

A second 4-bit code selects one of seven conditions. The condition is evaluated against the flags already held in the register, and the single result bit serves both conditional register moves and conditional jumps. The operands come from logic outside the block, and the result is consumed outside it as well.

Top module: `alu_cc_unit`

## Requirements
- R1: `alu_out` is combinational. Operation code 0 gives `src_a + src_b`, 1 gives `src_b - src_a`, 2 gives bitwise AND and 3 gives bitwise XOR, all modulo 2^32.
- R2: On a clock edge where `flag_we` is high and the operation code is 0 to 3, `flag_z` becomes 1 exactly when the result is zero, and `flag_s` takes the result's bit 31.
- R3: On such an edge, `flag_v` records two's-complement overflow for code 0 (operands of equal sign, result of the other sign) and for code 1 (`src_b` and `src_a` of different sign, result sign differing from `src_b`). For codes 2 and 3, `flag_v` is cleared to 0.
- R4: On a clock edge with `flag_we` low, all three flags keep their values.
- R5: While `rst_n` is low, the flags are `flag_z`=1, `flag_s`=0 and `flag_v`=0.
- R6: `cond_hit` is combinational from the stored flags. With lt = `flag_s` xor `flag_v`, the codes are: 0 gives 1; 1 gives lt or `flag_z`; 2 gives lt; 3 gives `flag_z`; 4 gives not `flag_z`; 5 gives not lt; 6 gives not lt and not `flag_z`. When a flag write occurs in the same cycle, `cond_hit` still reflects the flags held before that edge.
- R7: Condition codes 7 to 15 give `cond_hit` = 0.
- R8: Operation codes 4 to 15 give `alu_out` = 0 and leave the flags unchanged even when `flag_we` is high.
- R9: An add with `flag_we` high gives (Z,S,V) as follows: 1+2 gives 0,0,0; 0x80000000+0xFFFFFFFF gives 0,0,1; 1+0xFFFFFFFE gives 0,1,0; 5+0xFFFFFFFB gives 1,0,0; 0x80000000+0x80000000 gives 1,0,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flag register |
| src_a | input | 32 | First operand (subtrahend for code 1) |
| src_b | input | 32 | Second operand (minuend for code 1) |
| op_sel | input | 4 | Operation code |
| flag_we | input | 1 | Flag-write strobe |
| cond_sel | input | 4 | Condition code |
| alu_out | output | 32 | Operation result |
| flag_z | output | 1 | Stored zero flag |
| flag_s | output | 1 | Stored negative flag |
| flag_v | output | 1 | Stored overflow flag |
| cond_hit | output | 1 | Selected condition is true |

## Verification
A flag update and a condition evaluation can fall in the same cycle. This happens when an operation with `flag_we` high is presented together with a condition code whose answer would differ under the new flags. The bench provokes this by choosing operations that flip the zero or overflow flag while `cond_sel` asks for equal, less or greater. It then judges `cond_hit` before the edge against the flags the reference model held before the write. After the edge, the next cycle's flag outputs are judged against the model's updated flags.

// File: rtl/alu_cc_unit.sv
module alu_cc_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [3:0]   op_sel,
  input  logic         flag_we,
  input  logic [3:0]   cond_sel,
  output logic [W-1:0] alu_out,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_v,
  output logic         cond_hit
);

  localparam int MSB = W - 1;
  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_SUB = 4'd1;
  localparam logic [3:0] OP_AND = 4'd2;
  localparam logic [3:0] OP_XOR = 4'd3;

  logic [W-1:0] sum, diff;
  logic         ovf, op_ok;

  assign sum  = src_a + src_b;
  assign diff = src_b - src_a;

  always_comb begin
    alu_out = '0;
    ovf     = 1'b0;
    op_ok   = 1'b1;
    case (op_sel)
      OP_ADD: begin
        alu_out = sum;
        ovf     = (src_a[MSB] == src_b[MSB]) && (sum[MSB] != src_a[MSB]);
      end
      OP_SUB: begin
        alu_out = diff;
        ovf     = (src_a[MSB] != src_b[MSB]) && (diff[MSB] != src_b[MSB]);
      end
      OP_AND:  alu_out = src_a & src_b;
      OP_XOR:  alu_out = src_a ^ src_b;
      default: op_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_z <= 1'b1;
      flag_s <= 1'b0;
      flag_v <= 1'b0;
    end else if (flag_we && op_ok) begin
      flag_z <= (alu_out == '0);
      flag_s <= alu_out[MSB];
      flag_v <= ovf;
    end
  end

  logic lt;
  assign lt = flag_s ^ flag_v;

  always_comb begin
    case (cond_sel)
      4'd0:    cond_hit = 1'b1;
      4'd1:    cond_hit = lt | flag_z;
      4'd2:    cond_hit = lt;
      4'd3:    cond_hit = flag_z;
      4'd4:    cond_hit = ~flag_z;
      4'd5:    cond_hit = ~lt;
      4'd6:    cond_hit = ~lt & ~flag_z;
      default: cond_hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_cc_checks.sv
module alu_cc_checks #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic [3:0]   op_sel,
  input logic         flag_we,
  input logic [3:0]   cond_sel,
  input logic [W-1:0] alu_out,
  input logic         flag_z,
  input logic         flag_s,
  input logic         flag_v,
  input logic         cond_hit
);

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable({flag_z, flag_s, flag_v})); // R4

  AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_sel < 4'd4) |=>
      (flag_z == ($past(alu_out) == '0)) && (flag_s == $past(alu_out[W-1]))); // R2

  AST_LOGIC_CLEARS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op_sel == 4'd2 || op_sel == 4'd3)) |=> !flag_v); // R3

  AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_sel == 4'd0) |=>
      flag_v == (($past(src_a[W-1]) == $past(src_b[W-1])) &&
                 ($past(alu_out[W-1]) != $past(src_a[W-1])))); // R3

  AST_BAD_OP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > 4'd3) |=> $stable({flag_z, flag_s, flag_v})); // R8

  AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > 4'd3) |-> alu_out == '0); // R8

  AST_BAD_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel > 4'd6) |-> !cond_hit); // R7

  AST_EQ_NE: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd3 || cond_sel == 4'd4) |-> (cond_hit == (flag_z ^ cond_sel[2]))); // R6

endmodule

bind alu_cc_unit alu_cc_checks #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .op_sel(op_sel),
  .flag_we(flag_we), .cond_sel(cond_sel), .alu_out(alu_out), .flag_z(flag_z),
  .flag_s(flag_s), .flag_v(flag_v), .cond_hit(cond_hit)
);

// File: tb/tb_alu_cc_unit.sv
`timescale 1ns/1ps
module tb_alu_cc_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] src_a = 0, src_b = 0;
  logic [3:0]  op_sel = 0, cond_sel = 0;
  logic        flag_we = 0;
  logic [31:0] alu_out;
  logic        flag_z, flag_s, flag_v, cond_hit;

  int total = 0, bad = 0;
  bit done = 0;
  bit mz = 1, ms = 0, mv = 0;

  always #4 clk = ~clk;

  alu_cc_unit dut (.*);

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  function automatic bit model_cond(input [3:0] c);
    bit lt;
    lt = ms ^ mv;
    case (c)
      0: return 1;
      1: return lt || mz;
      2: return lt;
      3: return mz;
      4: return !mz;
      5: return !lt;
      6: return !lt && !mz;
      default: return 0;
    endcase
  endfunction

  task automatic step(input [31:0] a, input [31:0] b, input [3:0] fn, input bit we,
                      input [3:0] cf, input string tag);
    longint sa, sb, s;
    logic [31:0] res;
    bit ov, ok;
    @(negedge clk);
    src_a = a; src_b = b; op_sel = fn; flag_we = we; cond_sel = cf;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ok = 1; ov = 0; res = 0;
    case (fn)
      0: begin s = sa + sb; res = s[31:0]; ov = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      1: begin s = sb - sa; res = s[31:0]; ov = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      2: res = a & b;
      3: res = a ^ b;
      default: ok = 0;
    endcase
    #2;
    chk(tag, "result", alu_out, res);
    chk(tag, "flags", {flag_z, flag_s, flag_v}, {mz, ms, mv});
    chk(tag, "cond", cond_hit, model_cond(cf));
    @(posedge clk);
    if (we && ok) begin
      mz = (res == 0);
      ms = res[31];
      mv = ov;
    end
  endtask

  localparam logic [31:0] TMIN = 32'h8000_0000;
  localparam logic [31:0] TMAX = 32'h7FFF_FFFF;
  localparam logic [31:0] NEG1 = 32'hFFFF_FFFF;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R5", "reset flags", {flag_z, flag_s, flag_v}, 3'b100);
    rst_n = 1;
    step(0, 0, 4'd9, 0, 4'd3, "R5");

    step(1, 2, 0, 1, 0, "R1");
    step(3, 10, 1, 1, 0, "R1");
    step(10, 3, 1, 1, 0, "R1");
    step(32'hF0F0_1234, 32'h0FF0_FF00, 2, 1, 0, "R1");
    step(32'hF0F0_1234, 32'h0FF0_FF00, 3, 1, 0, "R1");

    step(1, 2, 0, 1, 0, "R9");
    step(TMIN, NEG1, 0, 1, 0, "R9");
    step(1, 32'hFFFF_FFFE, 0, 1, 0, "R9");
    step(5, 32'hFFFF_FFFB, 0, 1, 0, "R9");
    step(TMIN, TMIN, 0, 1, 0, "R9");
    step(0, 0, 4'd15, 0, 0, "R9");

    step(7, 7, 1, 1, 0, "R2");
    step(0, TMIN, 3, 1, 0, "R2");
    step(1, TMIN, 1, 1, 0, "R3");
    step(NEG1, TMAX, 1, 1, 0, "R3");
    step(TMIN, NEG1, 0, 1, 0, "R3");
    step(NEG1, NEG1, 2, 1, 0, "R3");
    step(TMIN, NEG1, 0, 1, 0, "R3");
    step(TMIN, 1, 3, 1, 0, "R3");
    step(0, 0, 4'd15, 0, 0, "R3");

    step(5, 5, 1, 0, 3, "R4");
    step(TMIN, TMIN, 0, 0, 2, "R4");
    step(0, 0, 4'd15, 0, 0, "R4");

    step(3, 3, 4'd4, 1, 0, "R8");
    step(NEG1, 1, 4'd12, 1, 0, "R8");
    step(0, 0, 4'd15, 1, 0, "R8");

    step(0, 0, 2, 1, 0, "R6");
    for (int c = 0; c < 16; c++) step(0, 0, 4'd9, 0, 4'(c), c < 7 ? "R6" : "R7");
    step(1, 32'hFFFF_FFFE, 0, 1, 0, "R6");
    for (int c = 0; c < 16; c++) step(0, 0, 4'd9, 0, 4'(c), c < 7 ? "R6" : "R7");
    step(TMIN, NEG1, 0, 1, 0, "R6");
    for (int c = 0; c < 16; c++) step(0, 0, 4'd9, 0, 4'(c), c < 7 ? "R6" : "R7");
    step(1, 5, 1, 1, 0, "R6");
    for (int c = 0; c < 16; c++) step(0, 0, 4'd9, 0, 4'(c), c < 7 ? "R6" : "R7");

    step(4, 4, 1, 1, 4'd3, "R6");
    step(4, 9, 1, 1, 4'd3, "R6");
    step(1, TMIN, 1, 1, 4'd2, "R6");
    step(1, 1, 2, 1, 4'd5, "R6");
    step(0, 0, 4'd9, 0, 4'd6, "R6");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule